// File: doc/BRIEF.md
# Reply Frame Pair Detector

This block looks for bracket pulse pairs in a stream of single-cycle leading-edge strobes. Each strobe comes with a flag that marks the pulse as received on an antenna sidelobe. Every strobe and its flag enter a delay line. A frame is found when a new leading edge coincides with a delayed edge that is 167, 168 or 169 cycles old. That span is the nominal 20.3 µs bracket spacing, with its tolerance, expressed at the sampling clock. The older edge acts as the opening bracket and the new edge as the closing one.

Detections are suppressed in three cases: when both brackets are sidelobe pulses, when a detection would fall too close after the previous one, and while a long-reply header indication holds the detector off for 120 µs. Interleaved replies can produce phantom pairs, so the block tracks at most two replies at a time. A frame that arrives soon after another is reported as tentative. A later overlapping frame cancels it, and a quiet period confirms it. The first frame of a chain is always confirmed. Each frame carries a timestamp taken from a free-running cycle counter at the closing edge.

Top module: `frame_pair_det`

## Requirements
- R1: A frame strobe (`frame_o`) rises in the cycle after a leading edge for which a prior edge occurred exactly 167, 168 or 169 cycles earlier. Spacings of 166 and 170 produce no frame.
- R2: A pair in which both brackets carry the sidelobe flag gives no frame. A pair with the flag on only one bracket is detected.
- R3: A frame whose closing edge comes fewer than 3 cycles after the closing edge of the previous accepted frame is suppressed. A spacing of exactly 3 is accepted.
- R4: A header indication in cycle k blocks detection for closing edges in cycles k through k+994. A closing edge in cycle k+995 is detected.
- R5: A frame accepted 174 or more cycles after the previous accepted frame (or the first frame after reset) is reported with `tent_o` = 0, meaning confirmed at once.
- R6: A frame accepted fewer than 174 cycles after the previous accepted frame is reported with `tent_o` = 1.
- R7: When a tentative frame is accepted while an earlier tentative frame is still pending, `cancel_o` pulses together with the new frame strobe and withdraws the earlier one.
- R8: A pending tentative frame that is not followed by another accepted frame is confirmed by a `confirm_o` pulse exactly 173 cycles after its own frame strobe. If a frame is accepted in that same cycle, the cancel wins and no confirmation is issued.
- R9: `ts_o` holds the free-running cycle count of the closing edge, so the difference between two frame timestamps equals the spacing of their closing edges.
- R10: After reset, `frame_o`, `tent_o`, `confirm_o` and `cancel_o` are low and `ts_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| le_i | input | 1 | Leading-edge strobe, one cycle per pulse |
| sl_i | input | 1 | Sidelobe flag qualifying `le_i` |
| hdr_i | input | 1 | Long-reply header seen (starts the hold-off) |
| frame_o | output | 1 | Frame detected strobe |
| tent_o | output | 1 | Frame is tentative (valid with `frame_o`) |
| confirm_o | output | 1 | Pending tentative frame confirmed |
| cancel_o | output | 1 | Pending tentative frame withdrawn |
| ts_o | output | TS_W | Cycle count of the closing edge of the last frame |

## Verification
Two resolutions can meet in one cycle. The expiry that confirms a pending tentative frame can fall in the same cycle as the acceptance of a new overlapping frame, and the gap inhibit can fall in the same cycle as a valid coincidence. The bench provokes the first case by placing a closing edge exactly 173 cycles after a tentative frame and expects a cancel with no confirmation. It then places the next frame 174 cycles later, which must see the confirmation one cycle before a non-tentative frame. For the second case, the bench interleaves two openings 2 and then 3 cycles apart, so that a genuine coincidence lands inside and then at the edge of the inhibit.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

   // Events produced by the chain resolver, registered once.
   typedef struct packed {
      logic frame;
      logic tent;
      logic confirm;
      logic cancel;
   } fpd_evt_t;

endpackage

// File: rtl/fpd_delay.sv
// Edge/flag delay line; exposes only the oldest WIN taps (the coincidence window).
module fpd_delay #(
   parameter int DEPTH = 169,
   parameter int WIN   = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           le_i,
   input  logic           sl_i,
   output logic [WIN-1:0] le_win,
   output logic [WIN-1:0] sl_win
);

   logic [DEPTH-1:0] le_sr;
   logic [DEPTH-1:0] sl_sr;

   // le_sr[k] holds the edge seen k+1 cycles ago.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         le_sr <= '0;
         sl_sr <= '0;
      end else begin
         le_sr <= {le_sr[DEPTH-2:0], le_i};
         sl_sr <= {sl_sr[DEPTH-2:0], sl_i};
      end
   end

   assign le_win = le_sr[DEPTH-1 -: WIN];
   assign sl_win = sl_sr[DEPTH-1 -: WIN];

endmodule

// File: rtl/fpd_coinc.sv
// Coincidence of the current edge with any delayed edge in the window,
// rejecting a pair whose two brackets are both sidelobe pulses.
module fpd_coinc #(
   parameter int WIN = 3
) (
   input  logic           le_i,
   input  logic           sl_i,
   input  logic [WIN-1:0] le_win,
   input  logic [WIN-1:0] sl_win,
   output logic           hit_o
);

   logic [WIN-1:0] pair_ok;

   for (genvar i = 0; i < WIN; i++) begin : g_tap
      assign pair_ok[i] = le_win[i] & ~(sl_win[i] & sl_i);
   end

   assign hit_o = le_i & (|pair_ok);

endmodule

// File: rtl/fpd_inhibit.sv
// Minimum-gap inhibit and long-reply hold-off.
module fpd_inhibit #(
   parameter int MIN_GAP = 3,
   parameter int MS_HOLD = 994
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hdr_i,
   input  logic acc_i,
   output logic inh_o
);

   localparam int GW = $clog2(MIN_GAP + 1);

   logic [GW-1:0] gap_q;
   logic          ms_inh;

   // Cycles since the last accepted frame, saturating at MIN_GAP.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q <= GW'(MIN_GAP);
      end else if (acc_i) begin
         gap_q <= GW'(1);
      end else if (gap_q < GW'(MIN_GAP)) begin
         gap_q <= gap_q + GW'(1);
      end
   end

   if (MS_HOLD > 0) begin : g_hold
      localparam int MW = $clog2(MS_HOLD + 1);
      logic [MW-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
         end else if (hdr_i) begin
            hold_q <= MW'(MS_HOLD);
         end else if (hold_q != '0) begin
            hold_q <= hold_q - MW'(1);
         end
      end
      assign ms_inh = hdr_i | (hold_q != '0);
   end else begin : g_nohold
      assign ms_inh = hdr_i;
   end

   assign inh_o = ms_inh | (gap_q < GW'(MIN_GAP));

endmodule

// File: rtl/fpd_chain.sv
// Phantom resolution: one anchor (last accepted frame) plus one pending tentative frame.
module fpd_chain
   import fpd_pkg::*;
#(
   parameter int TENT_WIN = 174
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     acc_i,
   output fpd_evt_t evt_o
);

   localparam int SW = $clog2(TENT_WIN + 1);

   logic [SW-1:0] since_q;
   logic          pend_q;
   logic          recent;

   assign recent = since_q < SW'(TENT_WIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= SW'(TENT_WIN);
         pend_q  <= 1'b0;
         evt_o   <= '0;
      end else begin
         evt_o <= '0;
         if (acc_i) begin
            since_q     <= SW'(1);
            evt_o.frame <= 1'b1;
            if (recent) begin
               evt_o.tent   <= 1'b1;
               evt_o.cancel <= pend_q;
               pend_q       <= 1'b1;
            end else begin
               pend_q <= 1'b0;
            end
         end else begin
            if (recent) begin
               since_q <= since_q + SW'(1);
            end
            if (pend_q && since_q == SW'(TENT_WIN - 1)) begin
               evt_o.confirm <= 1'b1;
               pend_q        <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/frame_pair_det.sv
module frame_pair_det
   import fpd_pkg::*;
#(
   parameter int DLY_MIN  = 167,
   parameter int DLY_MAX  = 169,
   parameter int MIN_GAP  = 3,
   parameter int MS_HOLD  = 994,
   parameter int TENT_WIN = 174,
   parameter int TS_W     = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            le_i,
   input  logic            sl_i,
   input  logic            hdr_i,
   output logic            frame_o,
   output logic            tent_o,
   output logic            confirm_o,
   output logic            cancel_o,
   output logic [TS_W-1:0] ts_o
);

   localparam int WIN = DLY_MAX - DLY_MIN + 1;

   if (DLY_MIN < 2 || DLY_MAX < DLY_MIN) begin : g_bad_dly
      $error("frame_pair_det: need 2 <= DLY_MIN <= DLY_MAX");
   end
   if (MIN_GAP < 1) begin : g_bad_gap
      $error("frame_pair_det: MIN_GAP must be at least 1");
   end
   if (TENT_WIN < 2) begin : g_bad_tent
      $error("frame_pair_det: TENT_WIN must be at least 2");
   end
   if (TS_W < 2) begin : g_bad_ts
      $error("frame_pair_det: TS_W must be at least 2");
   end

   logic [WIN-1:0] le_win;
   logic [WIN-1:0] sl_win;
   logic           hit;
   logic           inh;
   logic           acc;
   fpd_evt_t       evt;
   logic [TS_W-1:0] tm_q;

   fpd_delay #(.DEPTH(DLY_MAX), .WIN(WIN)) u_delay (
      .clk    (clk),
      .rst_n  (rst_n),
      .le_i   (le_i),
      .sl_i   (sl_i),
      .le_win (le_win),
      .sl_win (sl_win)
   );

   fpd_coinc #(.WIN(WIN)) u_coinc (
      .le_i   (le_i),
      .sl_i   (sl_i),
      .le_win (le_win),
      .sl_win (sl_win),
      .hit_o  (hit)
   );

   fpd_inhibit #(.MIN_GAP(MIN_GAP), .MS_HOLD(MS_HOLD)) u_inh (
      .clk   (clk),
      .rst_n (rst_n),
      .hdr_i (hdr_i),
      .acc_i (acc),
      .inh_o (inh)
   );

   assign acc = hit & ~inh;

   fpd_chain #(.TENT_WIN(TENT_WIN)) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .acc_i (acc),
      .evt_o (evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tm_q <= '0;
         ts_o <= '0;
      end else begin
         tm_q <= tm_q + TS_W'(1);
         if (acc) begin
            ts_o <= tm_q;
         end
      end
   end

   assign frame_o   = evt.frame;
   assign tent_o    = evt.tent;
   assign confirm_o = evt.confirm;
   assign cancel_o  = evt.cancel;

endmodule

// File: rtl/fpd_checker.sv
module fpd_checker (
   input logic clk,
   input logic rst_n,
   input logic le_i,
   input logic hdr_i,
   input logic frame_o,
   input logic tent_o,
   input logic confirm_o,
   input logic cancel_o
);

   assert_frame_needs_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
      frame_o |-> $past(le_i));

   assert_min_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_o |-> (!$past(frame_o) && !$past(frame_o, 2)));

   assert_hold_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hdr_i) |-> !frame_o);

   assert_cancel_with_tent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_o |-> (frame_o && tent_o));

   assert_confirm_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
      confirm_o |-> !frame_o);

endmodule

bind frame_pair_det fpd_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .le_i      (le_i),
   .hdr_i     (hdr_i),
   .frame_o   (frame_o),
   .tent_o    (tent_o),
   .confirm_o (confirm_o),
   .cancel_o  (cancel_o)
);

// File: tb/frame_pair_det_tb.sv
`timescale 1ns/1ps
module frame_pair_det_tb;

   localparam int TS_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic le_i = 1'b0, sl_i = 1'b0, hdr_i = 1'b0;
   logic frame_o, tent_o, confirm_o, cancel_o;
   logic [TS_W-1:0] ts_o;

   int n_chk = 0, n_bad = 0;
   int cyc = 0, fr_cnt = 0, fr_cyc = 0, cf_cnt = 0, cf_cyc = 0, cn_cnt = 0;
   int fr_ts = 0;
   logic fr_tent = 1'b0, fr_cancel = 1'b0;
   bit done = 0;

   always #4 clk = ~clk;

   frame_pair_det #(.TS_W(TS_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .le_i(le_i), .sl_i(sl_i), .hdr_i(hdr_i),
      .frame_o(frame_o), .tent_o(tent_o), .confirm_o(confirm_o),
      .cancel_o(cancel_o), .ts_o(ts_o)
   );

   // Event monitor, sampled 2 ns after each rising edge.
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         cyc++;
         if (frame_o) begin
            fr_cnt++;
            fr_cyc = cyc;
            fr_tent = tent_o;
            fr_cancel = cancel_o;
            fr_ts = int'(ts_o);
            if (cancel_o) cn_cnt++;
         end
         if (confirm_o) begin
            cf_cnt++;
            cf_cyc = cyc;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input logic le, input logic sl, input logic hdr);
      le_i = le; sl_i = sl; hdr_i = hdr;
      @(negedge clk);
      le_i = 1'b0; sl_i = 1'b0; hdr_i = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0);
   endtask

   task automatic edge1(input logic sl);
      tick(1'b1, sl, 1'b0);
   endtask

   task automatic t_reset();
      check(frame_o == 0 && tent_o == 0 && confirm_o == 0 && cancel_o == 0,
            "R10 strobes", {frame_o, tent_o, confirm_o, cancel_o}, 0);
      check(ts_o == 0, "R10 ts", int'(ts_o), 0);
   endtask

   task automatic t_window(input int d, input int exp);
      int f0, t2;
      f0 = fr_cnt;
      edge1(1'b0); idle(d - 1); edge1(1'b0); t2 = cyc;
      check(fr_cnt - f0 == exp, $sformatf("R1 spacing %0d", d), fr_cnt - f0, exp);
      if (exp == 1) begin
         check(fr_cyc == t2, "R1 strobe cycle", fr_cyc, t2);
         check(fr_tent == 0, "R5 isolated frame confirmed", fr_tent, 0);
      end
      idle(400);
   endtask

   task automatic t_sidelobe(input logic s1, input logic s2, input int exp);
      int f0;
      f0 = fr_cnt;
      edge1(s1); idle(167); edge1(s2);
      check(fr_cnt - f0 == exp, $sformatf("R2 flags %0d%0d", s1, s2), fr_cnt - f0, exp);
      idle(400);
   endtask

   task automatic t_gap();
      int f0, c0, t2;
      f0 = fr_cnt;
      edge1(0); idle(1); edge1(0); idle(165); edge1(0); idle(1); edge1(0);
      check(fr_cnt - f0 == 1, "R3 gap 2 suppressed", fr_cnt - f0, 1);
      idle(400);
      f0 = fr_cnt; c0 = cf_cnt;
      edge1(0); idle(2); edge1(0); idle(164); edge1(0);
      check(fr_tent == 0, "R5 first of pair", fr_tent, 0);
      idle(2); edge1(0); t2 = cyc;
      check(fr_cnt - f0 == 2, "R3 gap 3 accepted", fr_cnt - f0, 2);
      check(fr_tent == 1 && fr_cancel == 0, "R6 tentative no cancel",
            {fr_tent, fr_cancel}, 2);
      idle(173);
      check(cf_cnt - c0 == 1 && cf_cyc == t2 + 173, "R8 confirm at +173",
            cf_cyc - t2, 173);
      idle(400);
   endtask

   task automatic t_hold(input int off, input int exp);
      int f0;
      f0 = fr_cnt;
      tick(1'b0, 1'b0, 1'b1);
      idle(off - 169); edge1(0); idle(167); edge1(0);
      check(fr_cnt - f0 == exp, $sformatf("R4 closing at +%0d", off), fr_cnt - f0, exp);
      idle(400);
   endtask

   task automatic t_chain();
      int tsa, tc, c0, n0;
      c0 = cf_cnt; n0 = cn_cnt;
      edge1(0); idle(99); edge1(0); idle(67); edge1(0); tsa = fr_ts;
      check(fr_tent == 0, "R5 chain head confirmed", fr_tent, 0);
      idle(31); edge1(0); idle(67); edge1(0);
      check(fr_tent == 1 && fr_cancel == 0, "R6 second tentative", {fr_tent, fr_cancel}, 2);
      idle(99); edge1(0); tc = cyc;
      check(fr_tent == 1 && fr_cancel == 1, "R7 overlap cancels", {fr_tent, fr_cancel}, 3);
      check(fr_ts - tsa == 200, "R9 timestamp delta", fr_ts - tsa, 200);
      check(cf_cnt == c0, "R8 middle never confirmed", cf_cnt - c0, 0);
      idle(173);
      check(cf_cnt - c0 == 1 && cf_cyc == tc + 173, "R8 tail confirmed", cf_cyc - tc, 173);
      check(cn_cnt - n0 == 1, "R7 one cancel", cn_cnt - n0, 1);
      idle(400);
   endtask

   task automatic t_collide();
      int tc, c0;
      c0 = cf_cnt;
      edge1(0); idle(49); edge1(0); idle(117); edge1(0);
      check(fr_tent == 0, "R5 head", fr_tent, 0);
      idle(49); edge1(0);
      check(fr_tent == 1, "R6 second", fr_tent, 1);
      idle(4); edge1(0); idle(167); edge1(0); tc = cyc;
      check(fr_tent == 1 && fr_cancel == 1 && cf_cnt == c0,
            "R8 cancel beats confirm at 173", {fr_tent, fr_cancel}, 3);
      idle(5); edge1(0); idle(167); edge1(0);
      check(cf_cnt - c0 == 1 && cf_cyc == tc + 173, "R8 confirm before next",
            cf_cyc - tc, 173);
      check(fr_tent == 0, "R5 frame at 174 confirmed", fr_tent, 0);
      idle(400);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      idle(5);
      t_window(166, 0);
      t_window(167, 1);
      t_window(168, 1);
      t_window(169, 1);
      t_window(170, 0);
      t_sidelobe(1'b1, 1'b1, 0);
      t_sidelobe(1'b1, 1'b0, 1);
      t_sidelobe(1'b0, 1'b1, 1);
      t_gap();
      t_hold(994, 0);
      t_hold(995, 1);
      t_chain();
      t_collide();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule